// File: doc/BRIEF.md
# Boot Configuration Byte Loader

After reset is released, this sequencer fetches two configuration bytes over a simple external-memory handshake. It latches them into two configuration registers that cannot change again until the next reset. When both bytes are in place it raises a done flag, which releases the rest of the system.

The first fetch always runs with safe bus settings: an 8-bit multiplexed bus and three wait states. The second fetch takes its wait-state count, bus width and address/data multiplexing from fields of the first byte. In both fetches a low ready input stretches the bus cycle past the programmed wait count. Each returned byte comes from the low byte lane of the read-data bus.

The controller has three states:
- `ST_FETCH0` reads the first byte.
- `ST_FETCH1` reads the second byte.
- `ST_DONE` holds everything.

It has two transitions:
- `ST_FETCH0 -> ST_FETCH1` on acceptance of the first byte.
- `ST_FETCH1 -> ST_DONE` on acceptance of the second byte.

`ST_DONE` is left only by reset.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is asserted, `cfg_done`, `cfg0_q` and `cfg1_q` are 0. They stay at 0 until the second fetch has been accepted.
- R2: The first fetch presents address FF2018h with `bus_wide`=0 and `bus_demux`=0. A fetch is accepted in the first of its cycles (counted from 0) whose index is at least 3 and in which `bus_rdy`=1. With ready low for its first n cycles, the fetch therefore lasts max(3,n)+1 cycles.
- R3: The second fetch presents address FF201Ah. It drives `bus_wide` from bit 1 of the first byte (1 = 16-bit bus) and `bus_demux` from bit 3 of the first byte (1 = demultiplexed).
- R4: The wait count of the second fetch is ws = bits 5:4 of the first byte (0 to 3). The fetch is accepted in its first cycle whose index is at least ws and in which `bus_rdy`=1, so it lasts max(ws,n)+1 cycles.
- R5: The byte taken by each fetch is `bus_rdata[7:0]` in the accepting cycle, for both the 8-bit bus and the 16-bit bus at an even address. Bits 15:8 and data in cycles that are not accepted have no effect.
- R6: `cfg_done` rises in the cycle right after the second fetch is accepted. In that same cycle `cfg0_q` shows the first byte and `cfg1_q` shows the second.
- R7: Once `cfg_done` is 1, `bus_req` is 0. From then until reset, `cfg0_q`, `cfg1_q` and `cfg_done` do not change, whatever `bus_rdy` and `bus_rdata` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rdy | input | 1 | Ready from external memory; low stretches the bus cycle |
| bus_rdata | input | 16 | Read data, low byte lane in bits 7:0 |
| bus_req | output | 1 | Fetch in progress |
| bus_addr | output | 24 | Byte address of the current fetch |
| bus_wide | output | 1 | 1 = 16-bit bus for this fetch |
| bus_demux | output | 1 | 1 = demultiplexed bus for this fetch |
| cfg0_q | output | 8 | Latched first configuration byte |
| cfg1_q | output | 8 | Latched second configuration byte |
| cfg_done | output | 1 | Both bytes latched; system may proceed |

## Verification
The assertions assume two things about the environment. Reset is held for at least one clock. The memory side answers only through `bus_rdy` and `bus_rdata`, with no further handshake. The wait counter's bound also relies on the wait count staying fixed while a fetch runs, which the design ensures by taking it from the staged first byte.

The bench meets these assumptions by construction. It drives ready as a delay per fetch: low for a random 0 to 6 cycles, then high. It puts the correct byte on the low lane only while ready is high, and random junk everywhere else. Directed trials cover the extreme wait counts and ready delays, the 16-bit demultiplexed settings, and the behaviour once loading is done.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 16;
    localparam int CFG_W     = 8;
    localparam int WS_W      = 2;
    // field positions inside the first byte, decoded for the second fetch
    localparam int WS_LO     = 4;
    localparam int DEMUX_BIT = 3;
    localparam int WIDE_BIT  = 1;
    localparam logic [ADDR_W-1:0] CFG0_ADDR = 24'hFF2018;
    localparam logic [ADDR_W-1:0] CFG1_ADDR = 24'hFF201A;
    localparam logic [WS_W-1:0]   BOOT_WS   = '1;

    typedef enum logic [1:0] {
        ST_FETCH0,
        ST_FETCH1,
        ST_DONE
    } ldr_state_e;
endpackage

// File: rtl/cfg_wait_ctr.sv
module cfg_wait_ctr #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [WS_W-1:0] ws_i,
    input  logic            rdy_i,
    output logic            fin_o
);
    logic [WS_W-1:0] cnt_q;

    assign fin_o = en_i && (cnt_q == ws_i) && rdy_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || fin_o) begin
            cnt_q <= '0;
        end else if (cnt_q != ws_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: counter never passes the programmed wait count; READY extends by holding
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q <= ws_i));
endmodule

// File: rtl/cfg_lane_sel.sv
module cfg_lane_sel #(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 8,
    localparam int LANES = DATA_W / CFG_W,
    localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              wide_i,
    input  logic [LSB_W-1:0]  lsb_i,
    output logic [CFG_W-1:0]  byte_o
);
    logic [CFG_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata_i[g*CFG_W +: CFG_W];
    end

    always_comb begin
        if (wide_i) begin
            byte_o = lane[lsb_i];
        end else begin
            byte_o = lane[0];
        end
    end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cfg_boot_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int DATA_W_P = DATA_W,
    parameter int CFG_W_P  = CFG_W,
    localparam int LANES   = DATA_W_P / CFG_W_P,
    localparam int LSB_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rdy,
    input  logic [DATA_W_P-1:0] bus_rdata,
    output logic                bus_req,
    output logic [ADDR_W_P-1:0] bus_addr,
    output logic                bus_wide,
    output logic                bus_demux,
    output logic [CFG_W_P-1:0]  cfg0_q,
    output logic [CFG_W_P-1:0]  cfg1_q,
    output logic                cfg_done
);
    ldr_state_e       state_q, state_d;
    logic [CFG_W_P-1:0] stage_q;
    logic [CFG_W_P-1:0] lane_byte;
    logic [WS_W-1:0]  ws_sel;
    logic             accept;

    cfg_wait_ctr #(.WS_W(WS_W)) wait_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (bus_req),
        .ws_i  (ws_sel),
        .rdy_i (bus_rdy),
        .fin_o (accept)
    );

    cfg_lane_sel #(.DATA_W(DATA_W_P), .CFG_W(CFG_W_P)) lane_i (
        .rdata_i (bus_rdata),
        .wide_i  (bus_wide),
        .lsb_i   (bus_addr[LSB_W-1:0]),
        .byte_o  (lane_byte)
    );

    // state register and latched configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FETCH0;
            stage_q  <= '0;
            cfg0_q   <= '0;
            cfg1_q   <= '0;
            cfg_done <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH0 && accept) begin
                stage_q <= lane_byte;
            end
            if (state_q == ST_FETCH1 && accept) begin
                cfg0_q   <= stage_q;
                cfg1_q   <= lane_byte;
                cfg_done <= 1'b1;
            end
        end
    end

    // next state and bus outputs
    always_comb begin
        state_d   = state_q;
        bus_req   = 1'b0;
        bus_addr  = '0;
        bus_wide  = 1'b0;
        bus_demux = 1'b0;
        ws_sel    = '0;
        unique case (state_q)
            ST_FETCH0: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W_P'(CFG0_ADDR);
                ws_sel   = BOOT_WS;
                if (accept) state_d = ST_FETCH1;
            end
            ST_FETCH1: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W_P'(CFG1_ADDR);
                bus_wide  = stage_q[WIDE_BIT];
                bus_demux = stage_q[DEMUX_BIT];
                ws_sel    = stage_q[WS_LO +: WS_W];
                if (accept) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_FETCH0;
        endcase
    end

    // R1: latched fields keep defaults until loading completes
    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (cfg0_q == '0 && cfg1_q == '0));

    // R2: first fetch lasts at least four cycles (three wait states)
    p_f0_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH1 && $past(state_q) == ST_FETCH0)
            |-> ($past(state_q, 4) == ST_FETCH0));

    // R7: configuration frozen after done
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (cfg_done && $stable(cfg0_q) && $stable(cfg1_q)));

    // R7: no bus activity after done
    p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !bus_req);
endmodule

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rdy = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        bus_req, bus_wide, bus_demux, cfg_done;
    logic [23:0] bus_addr;
    logic [7:0]  cfg0_q, cfg1_q;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [23:0] A0 = 24'hFF2018;
    localparam logic [23:0] A1 = 24'hFF201A;

    always #4 clk = ~clk;

    cfg_boot_loader dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_wide(bus_wide),
        .bus_demux(bus_demux), .cfg0_q(cfg0_q), .cfg1_q(cfg1_q),
        .cfg_done(cfg_done)
    );

    function automatic int exp_len(input int ws, input int n);
        return ((n > ws) ? n : ws) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic trial(input logic [7:0] b0, input logic [7:0] b1,
                         input int n0, input int n1);
        int len0 = 0, len1 = 0, steps = 0;
        bit seen_f1 = 0, f1_wide = 0, f1_demux = 0, f0_bad = 0, dflt_bad = 0;
        int ws = int'(b0[5:4]);
        logic [7:0] h0, h1;
        @(negedge clk);
        rst_n = 1'b0;
        bus_rdy = 1'b0;
        @(negedge clk);
        check(cfg_done == 1'b0 && cfg0_q == 8'h00 && cfg1_q == 8'h00,
              "R1 reset", {cfg_done, cfg0_q, cfg1_q}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 60; k++) begin
            int idx;
            if (cfg_done) break;
            if (cfg0_q != 8'h00 || cfg1_q != 8'h00) dflt_bad = 1;
            bus_rdy = 1'b0;
            bus_rdata = 16'($urandom);
            if (bus_req && bus_addr == A0) begin
                if (bus_wide || bus_demux) f0_bad = 1;
                idx = len0; len0++;
                bus_rdy = (idx >= n0);
                if (bus_rdy) bus_rdata = {8'($urandom), b0};
            end else if (bus_req && bus_addr == A1) begin
                if (!seen_f1) begin
                    seen_f1 = 1; f1_wide = bus_wide; f1_demux = bus_demux;
                end
                idx = len1; len1++;
                bus_rdy = (idx >= n1);
                if (bus_rdy) bus_rdata = {8'($urandom), b1};
            end
            steps++;
            @(negedge clk);
        end
        check(!dflt_bad, "R1 defaults before done", int'(dflt_bad), 0);
        check(!f0_bad, "R2 first fetch bus settings", int'(f0_bad), 0);
        check(len0 == exp_len(3, n0), "R2 first fetch length", len0, exp_len(3, n0));
        check(seen_f1 && f1_wide == b0[1], "R3 bus_wide", int'(f1_wide), int'(b0[1]));
        check(seen_f1 && f1_demux == b0[3], "R3 bus_demux", int'(f1_demux), int'(b0[3]));
        check(len1 == exp_len(ws, n1), "R4 second fetch length", len1, exp_len(ws, n1));
        check(cfg_done && steps == len0 + len1, "R6 done timing", steps, len0 + len1);
        check(cfg0_q == b0, "R5 cfg0 low lane", cfg0_q, b0);
        check(cfg1_q == b1, "R5 cfg1 low lane", cfg1_q, b1);
        h0 = cfg0_q; h1 = cfg1_q;
        for (int k = 0; k < 5; k++) begin
            bus_rdy = 1'($urandom);
            bus_rdata = 16'($urandom);
            @(negedge clk);
            check(!bus_req && cfg_done && cfg0_q == h0 && cfg1_q == h1,
                  "R7 frozen after done", {bus_req, cfg_done, cfg0_q, cfg1_q},
                  {1'b0, 1'b1, h0, h1});
        end
    endtask

    initial begin
        void'($urandom(32'd4417));
        // directed corners
        trial(8'hC0, 8'hA5, 0, 0);   // ws=0, ready immediate
        trial(8'hFA, 8'h3C, 0, 0);   // ws=3, 16-bit demux
        trial(8'h0A, 8'h81, 6, 6);   // ready stretches both
        trial(8'h32, 8'hFF, 2, 1);   // ws=3, n below count
        trial(8'h10, 8'h00, 4, 0);   // ws=1
        for (int t = 0; t < 30; t++) begin
            trial(8'($urandom), 8'($urandom), int'($urandom_range(0, 6)),
                  int'($urandom_range(0, 6)));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule